// File: doc/BRIEF.md
# Requester ID to MSI Sideband Mapper

This block turns the 16-bit identifier of a PCI requester into the sideband value that goes with an MSI write to one chosen MSI controller. In that identifier the bus number is in bits [15:8], the device number in bits [7:3] and the function number in bits [2:0]. The block holds a small table of range entries. Each entry has four fields: a first identifier, a length, the controller it serves, and the sideband value given to its first identifier. A single global mask clears identifier bits before any entry is compared. Because each entry is tied to one controller, one identifier can reach several controllers with different sideband values. A controller that no entry names for that identifier cannot be reached.

Software or a boot sequencer fills the table through a write port. Each write goes to one field of one entry, or to the mask. Interrupt logic then presents a requester ID and a controller index, and one cycle later gets a hit flag and the translated value. With two entries serving the same controller over opposite halves of the ID space, the top bus bit can be flipped or folded away, with no special case in the hardware.

Top module: `rid_msi_mapper`

## Requirements
- R1: After reset every entry is disabled, the mask is all ones and the result outputs are zero, so any lookup misses until entries are written.
- R2: The requester ID is ANDed with the global mask before range comparison and before the offset is computed. The mask is written with field code 5, and the entry index is ignored for that code.
- R3: An entry matches a masked ID r when r is at or above its base and below base plus length. The lower bound is inclusive and the upper bound is exclusive.
- R4: On a hit the sideband value is r minus the entry base plus the entry output base, truncated modulo 2^16.
- R5: An entry matches only when its controller field equals the lookup controller index. The same ID can return different values for different controllers, and a controller with no matching entry gets a miss.
- R6: When several enabled entries match for the selected controller, the entry with the lowest table index supplies the result.
- R7: The length field is 17 bits wide. A length of 0x10000 covers every ID from the base upward, and a length of 0 matches nothing.
- R8: On a miss the hit flag is 0 and the sideband output is 0.
- R9: A lookup presented with lk_valid high in one cycle gives res_valid, res_hit and res_sideband after the next rising edge. With lk_valid low, res_valid and res_hit go to 0 and res_sideband goes to 0 one cycle later.
- R10: A write with cfg_we high sets the field picked by cfg_field: 0 base, 1 controller, 2 output base, 3 length, 4 enable (bit 0), 5 mask. Codes 6 and 7 change nothing. A write affects lookups presented from the next cycle on. A lookup presented in the same cycle as a write sees the table as it was before that write.
- R11: Writing the enable field with bit 0 low disables an entry and leaves its other fields unchanged. Writing it with bit 0 high enables the entry again with those same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Entry index for the write |
| cfg_field | input | 3 | Field code for the write (see R10) |
| cfg_wdata | input | 17 | Write data, right-aligned |
| lk_valid | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Requester ID to translate |
| lk_ctrl | input | 4 | Index of the target MSI controller |
| res_valid | output | 1 | Result present, one cycle after lk_valid |
| res_hit | output | 1 | An entry matched |
| res_sideband | output | 16 | Translated sideband value, zero on a miss |

## Verification
A configuration write and a lookup can land in the same clock cycle, and the table has to settle which of them goes first. The bench sets up an entry that is still disabled. In one cycle it enables that entry and also presents an ID that falls inside the entry's range. It expects a miss, because the lookup reads the table from before the write. It then repeats the same lookup alone and expects the translated value.

// File: rtl/rid_map_pkg.sv
package rid_map_pkg;

   // Field selector codes of the configuration write port
   typedef enum logic [2:0] {
      FLD_BASE = 3'd0,
      FLD_CTRL = 3'd1,
      FLD_OUTB = 3'd2,
      FLD_LEN  = 3'd3,
      FLD_EN   = 3'd4,
      FLD_MASK = 3'd5
   } cfg_field_e;

   // Width of an entry index for a table of a given depth
   function automatic int idx_bits(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/rid_map_table.sv
module rid_map_table
   import rid_map_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int CTRL_W = 4,
   parameter int DEPTH  = 8,
   localparam int IDX_W = idx_bits(DEPTH),
   localparam int LEN_W = ID_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [IDX_W-1:0]              cfg_idx,
   input  logic [2:0]                    cfg_field,
   input  logic [LEN_W-1:0]              cfg_wdata,
   output logic [DEPTH-1:0][ID_W-1:0]    ent_base,
   output logic [DEPTH-1:0][CTRL_W-1:0]  ent_ctrl,
   output logic [DEPTH-1:0][ID_W-1:0]    ent_outb,
   output logic [DEPTH-1:0][LEN_W-1:0]   ent_len,
   output logic [DEPTH-1:0]              ent_en,
   output logic [ID_W-1:0]               glb_mask
);

   cfg_field_e fsel;
   assign fsel = cfg_field_e'(cfg_field);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_base <= '0;
         ent_ctrl <= '0;
         ent_outb <= '0;
         ent_len  <= '0;
         ent_en   <= '0;
         glb_mask <= '1;
      end else if (cfg_we) begin
         if (fsel == FLD_MASK) begin
            glb_mask <= cfg_wdata[ID_W-1:0];
         end
         for (int k = 0; k < DEPTH; k++) begin
            if (cfg_idx == IDX_W'(k)) begin
               case (fsel)
                  FLD_BASE: ent_base[k] <= cfg_wdata[ID_W-1:0];
                  FLD_CTRL: ent_ctrl[k] <= cfg_wdata[CTRL_W-1:0];
                  FLD_OUTB: ent_outb[k] <= cfg_wdata[ID_W-1:0];
                  FLD_LEN:  ent_len[k]  <= cfg_wdata;
                  FLD_EN:   ent_en[k]   <= cfg_wdata[0];
                  default:  ;
               endcase
            end
         end
      end
   end

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_field == FLD_MASK) |=> glb_mask == $past(cfg_wdata[ID_W-1:0])); // R10

   for (genvar k = 0; k < DEPTH; k++) begin : g_chk
      AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_field == FLD_EN && cfg_idx == IDX_W'(k))
         |=> ent_en[k] == $past(cfg_wdata[0])); // R11
      AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && cfg_field == FLD_EN && cfg_idx == IDX_W'(k))
         |=> $stable(ent_en[k])); // R11
      AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && cfg_field == FLD_BASE && cfg_idx == IDX_W'(k))
         |=> $stable(ent_base[k])); // R10
   end

endmodule

// File: rtl/rid_map_cmp.sv
module rid_map_cmp #(
   parameter int ID_W   = 16,
   parameter int CTRL_W = 4,
   localparam int LEN_W = ID_W + 1,
   localparam int SUM_W = ID_W + 2
) (
   input  logic [ID_W-1:0]    key,
   input  logic [CTRL_W-1:0]  sel_ctrl,
   input  logic [ID_W-1:0]    base,
   input  logic [CTRL_W-1:0]  tgt_ctrl,
   input  logic [ID_W-1:0]    outb,
   input  logic [LEN_W-1:0]   len,
   input  logic               en,
   output logic               hit,
   output logic [ID_W-1:0]    value
);

   logic [SUM_W-1:0] limit;
   logic [SUM_W-1:0] key_w;
   logic             above_lo;
   logic             below_hi;

   // Exclusive upper end kept one bit wider than the length field
   assign limit    = {2'b00, base} + {1'b0, len};
   assign key_w    = {2'b00, key};
   assign above_lo = (key >= base);
   assign below_hi = (key_w < limit);
   assign hit      = en && (tgt_ctrl == sel_ctrl) && above_lo && below_hi;
   // Modulo-2^ID_W offset translation
   assign value    = key - base + outb;

endmodule

// File: rtl/rid_map_prio.sv
module rid_map_prio #(
   parameter int ID_W  = 16,
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0]            match,
   input  logic [DEPTH-1:0][ID_W-1:0]  cand,
   output logic [DEPTH-1:0]            grant,
   output logic                        any,
   output logic [ID_W-1:0]             sel_value
);

   // Isolate the lowest set bit: lowest table index wins
   assign grant = match & (~match + DEPTH'(1));
   assign any   = |grant;

   always_comb begin
      sel_value = '0;
      for (int i = 0; i < DEPTH; i++) begin
         sel_value = sel_value | (cand[i] & {ID_W{grant[i]}});
      end
   end

endmodule

// File: rtl/rid_msi_mapper.sv
module rid_msi_mapper
   import rid_map_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int CTRL_W = 4,
   parameter int DEPTH  = 8,
   localparam int IDX_W = idx_bits(DEPTH),
   localparam int LEN_W = ID_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [2:0]         cfg_field,
   input  logic [LEN_W-1:0]   cfg_wdata,
   input  logic               lk_valid,
   input  logic [ID_W-1:0]    lk_rid,
   input  logic [CTRL_W-1:0]  lk_ctrl,
   output logic               res_valid,
   output logic               res_hit,
   output logic [ID_W-1:0]    res_sideband
);

   if (ID_W < 4 || ID_W > 32) begin : g_bad_id
      $error("rid_msi_mapper: ID_W out of range");
   end
   if (CTRL_W < 1 || CTRL_W > ID_W) begin : g_bad_ctrl
      $error("rid_msi_mapper: CTRL_W out of range");
   end
   if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
      $error("rid_msi_mapper: DEPTH out of range");
   end

   logic [DEPTH-1:0][ID_W-1:0]    ent_base;
   logic [DEPTH-1:0][CTRL_W-1:0]  ent_ctrl;
   logic [DEPTH-1:0][ID_W-1:0]    ent_outb;
   logic [DEPTH-1:0][LEN_W-1:0]   ent_len;
   logic [DEPTH-1:0]              ent_en;
   logic [ID_W-1:0]               glb_mask;
   logic [ID_W-1:0]               key;
   logic [DEPTH-1:0]              match;
   logic [DEPTH-1:0][ID_W-1:0]    cand;
   logic [DEPTH-1:0]              grant;
   logic                          any;
   logic [ID_W-1:0]               sel_value;

   rid_map_table #(.ID_W(ID_W), .CTRL_W(CTRL_W), .DEPTH(DEPTH)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .ent_base  (ent_base),
      .ent_ctrl  (ent_ctrl),
      .ent_outb  (ent_outb),
      .ent_len   (ent_len),
      .ent_en    (ent_en),
      .glb_mask  (glb_mask)
   );

   assign key = lk_rid & glb_mask;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      rid_map_cmp #(.ID_W(ID_W), .CTRL_W(CTRL_W)) u_cmp (
         .key      (key),
         .sel_ctrl (lk_ctrl),
         .base     (ent_base[e]),
         .tgt_ctrl (ent_ctrl[e]),
         .outb     (ent_outb[e]),
         .len      (ent_len[e]),
         .en       (ent_en[e]),
         .hit      (match[e]),
         .value    (cand[e])
      );
   end

   rid_map_prio #(.ID_W(ID_W), .DEPTH(DEPTH)) u_prio (
      .match     (match),
      .cand      (cand),
      .grant     (grant),
      .any       (any),
      .sel_value (sel_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_sideband <= '0;
      end else begin
         res_valid    <= lk_valid;
         res_hit      <= lk_valid && any;
         res_sideband <= (lk_valid && any) ? sel_value : '0;
      end
   end

   AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!res_valid && !res_hit && res_sideband == '0)); // R9
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> res_sideband == '0); // R8
   AST_MATCH_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && |match) |=> res_hit); // R5
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~match) == '0)); // R6

   for (genvar g = 1; g < DEPTH; g++) begin : g_prio_chk
      AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
         grant[g] |-> (match[g-1:0] == '0)); // R6
   end

endmodule

// File: tb/rid_msi_mapper_tb_top.sv
module rid_msi_mapper_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [2:0]  cfg_field = '0;
   logic [16:0] cfg_wdata = '0;
   logic        lk_valid = 1'b0;
   logic [15:0] lk_rid = '0;
   logic [3:0]  lk_ctrl = '0;
   logic        res_valid;
   logic        res_hit;
   logic [15:0] res_sideband;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rid_msi_mapper dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_idx      (cfg_idx),
      .cfg_field    (cfg_field),
      .cfg_wdata    (cfg_wdata),
      .lk_valid     (lk_valid),
      .lk_rid       (lk_rid),
      .lk_ctrl      (lk_ctrl),
      .res_valid    (res_valid),
      .res_hit      (res_hit),
      .res_sideband (res_sideband)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input int fld, input logic [16:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_idx   = 3'(idx);
      cfg_field = 3'(fld);
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic set_entry(input int idx, input logic [15:0] base, input logic [3:0] ctl,
                            input logic [15:0] outb, input logic [16:0] len);
      wr(idx, 0, {1'b0, base});
      wr(idx, 1, {13'd0, ctl});
      wr(idx, 2, {1'b0, outb});
      wr(idx, 3, len);
      wr(idx, 4, 17'd1);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 8; i++) wr(i, 4, 17'd0);
      wr(0, 5, 17'h0FFFF);
   endtask

   task automatic look(input string req, input logic [15:0] rid, input logic [3:0] ctl,
                       input logic exp_hit, input logic [15:0] exp_sb);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_rid   = rid;
      lk_ctrl  = ctl;
      @(negedge clk);
      lk_valid = 1'b0;
      check(req, {31'd0, res_valid}, 32'd1);
      check(req, {31'd0, res_hit}, {31'd0, exp_hit});
      check(req, {16'd0, res_sideband}, {16'd0, exp_sb});
   endtask

   task automatic t_reset();
      check("R1 valid", {31'd0, res_valid}, 32'd0);
      check("R1 hit", {31'd0, res_hit}, 32'd0);
      check("R1 sb", {16'd0, res_sideband}, 32'd0);
      look("R1 empty table", 16'h0000, 4'd0, 1'b0, 16'h0000);
      look("R1 empty table", 16'hFFFF, 4'd0, 1'b0, 16'h0000);
   endtask

   task automatic t_identity();
      clear_all();
      set_entry(0, 16'h0000, 4'd0, 16'h0000, 17'h10000);
      look("R7 full length", 16'hABCD, 4'd0, 1'b1, 16'hABCD);
      look("R7 full length top", 16'hFFFF, 4'd0, 1'b1, 16'hFFFF);
      look("R4 identity", 16'h0000, 4'd0, 1'b1, 16'h0000);
   endtask

   task automatic t_mask();
      clear_all();
      set_entry(2, 16'h0000, 4'd1, 16'h0000, 17'h00100);
      look("R2 unmasked miss", 16'h12F3, 4'd1, 1'b0, 16'h0000);
      wr(7, 5, 17'h000FF);
      look("R2 masked", 16'h12F3, 4'd1, 1'b1, 16'h00F3);
      look("R2 masked low", 16'hAB00, 4'd1, 1'b1, 16'h0000);
      wr(0, 6, 17'h1FFFF);
      wr(0, 7, 17'h1FFFF);
      look("R10 unused codes", 16'h12F3, 4'd1, 1'b1, 16'h00F3);
      wr(0, 5, 17'h0FFFF);
   endtask

   task automatic t_bounds();
      clear_all();
      set_entry(2, 16'h0100, 4'd2, 16'h4000, 17'h00020);
      look("R3 below base", 16'h00FF, 4'd2, 1'b0, 16'h0000);
      look("R3 at base", 16'h0100, 4'd2, 1'b1, 16'h4000);
      look("R3 last", 16'h011F, 4'd2, 1'b1, 16'h401F);
      look("R3 end exclusive", 16'h0120, 4'd2, 1'b0, 16'h0000);
   endtask

   task automatic t_invert();
      clear_all();
      set_entry(0, 16'h0000, 4'd3, 16'h8000, 17'h08000);
      set_entry(1, 16'h8000, 4'd3, 16'h0000, 17'h08000);
      look("R4 invert low", 16'h1234, 4'd3, 1'b1, 16'h9234);
      look("R4 invert high", 16'h9234, 4'd3, 1'b1, 16'h1234);
      look("R4 invert edge", 16'h7FFF, 4'd3, 1'b1, 16'hFFFF);
      look("R4 invert edge2", 16'h8000, 4'd3, 1'b1, 16'h0000);
      set_entry(3, 16'h0010, 4'd4, 16'hFFF0, 17'h00040);
      look("R4 modulo wrap", 16'h0030, 4'd4, 1'b1, 16'h0010);
   endtask

   task automatic t_multi_ctrl();
      clear_all();
      set_entry(0, 16'h0000, 4'd5, 16'h8000, 17'h08000);
      set_entry(1, 16'h0000, 4'd6, 16'h0000, 17'h10000);
      look("R5 ctrl a", 16'h0042, 4'd5, 1'b1, 16'h8042);
      look("R5 ctrl b", 16'h0042, 4'd6, 1'b1, 16'h0042);
      look("R5 unreachable ctrl", 16'h0042, 4'd7, 1'b0, 16'h0000);
      look("R8 range miss", 16'h9000, 4'd5, 1'b0, 16'h0000);
   endtask

   task automatic t_priority();
      clear_all();
      set_entry(5, 16'h0080, 4'd0, 16'h2000, 17'h00100);
      set_entry(3, 16'h0000, 4'd0, 16'h1000, 17'h00100);
      set_entry(1, 16'h0000, 4'd9, 16'h7000, 17'h10000);
      look("R6 lower index wins", 16'h0090, 4'd0, 1'b1, 16'h1090);
      look("R6 only higher", 16'h0100, 4'd0, 1'b1, 16'h2080);
      look("R6 other ctrl", 16'h0090, 4'd9, 1'b1, 16'h7090);
      set_entry(4, 16'h0050, 4'd2, 16'h0000, 17'h00000);
      look("R7 zero length", 16'h0050, 4'd2, 1'b0, 16'h0000);
   endtask

   task automatic t_enable();
      clear_all();
      set_entry(0, 16'h0000, 4'd0, 16'h0500, 17'h00010);
      look("R11 enabled", 16'h0003, 4'd0, 1'b1, 16'h0503);
      wr(0, 4, 17'd0);
      look("R11 disabled", 16'h0003, 4'd0, 1'b0, 16'h0000);
      wr(0, 4, 17'd1);
      look("R11 re-enabled", 16'h0003, 4'd0, 1'b1, 16'h0503);
   endtask

   task automatic t_same_cycle();
      clear_all();
      set_entry(0, 16'h0000, 4'd0, 16'h0300, 17'h00010);
      wr(0, 4, 17'd0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_field = 3'd4; cfg_wdata = 17'd1;
      lk_valid = 1'b1; lk_rid = 16'h0005; lk_ctrl = 4'd0;
      @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
      check("R10 same cycle valid", {31'd0, res_valid}, 32'd1);
      check("R10 same cycle sees old", {31'd0, res_hit}, 32'd0);
      check("R10 same cycle sb", {16'd0, res_sideband}, 32'd0);
      look("R10 next cycle sees new", 16'h0005, 4'd0, 1'b1, 16'h0305);
   endtask

   task automatic t_idle();
      look("R9 primed", 16'h0005, 4'd0, 1'b1, 16'h0305);
      @(negedge clk);
      check("R9 idle valid", {31'd0, res_valid}, 32'd0);
      check("R9 idle hit", {31'd0, res_hit}, 32'd0);
      check("R9 idle sb", {16'd0, res_sideband}, 32'd0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_identity();
            t_mask();
            t_bounds();
            t_invert();
            t_multi_ctrl();
            t_priority();
            t_enable();
            t_same_cycle();
            t_idle();
            done = 1'b1;
         end
         begin
            repeat (WATCHDOG) @(posedge clk);
            if (!done) begin
               n_cmp++;
               n_bad++;
               $display("FAIL watchdog: actual timeout expected completion");
            end
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule